// File: doc/BRIEF.md
# Leaf Interrupt Register Group

This block is one leaf of an interrupt tree. Event lines come in from up to 32 sources. An event is captured into a sticky identity register only when its mask bit is clear in the cycle it arrives. An event that arrives while masked is dropped for good. Software reads the captured bits over a simple register bus and acknowledges them by writing ones.

A separate enable register does not affect capture. It only gates which captured bits are passed upward. The block drives a per-bit pending vector and a single any-pending flag, which a parent aggregator combines with those of sibling leaves. A live view of the raw event levels can also be read.

The four registers sit at byte offsets 0x0 (live levels, read-only), 0x4 (mask), 0x8 (identity, write-one-to-clear) and 0xC (enable). A parent decoder may depend on these offsets.

Top module: `irq_leaf_unit`

## Requirements
- R1: After reset the mask reads all ones, the identity and enable registers read zero, and `pend_vec` and `pend_any` are zero.
- R2: An event bit that is high while its mask bit is 0 sets the identity bit at that clock edge, and the bit stays set after the event drops.
- R3: An event bit that is high while its mask bit is 1 leaves the identity bit unchanged, and the bit does not appear later when the mask is cleared.
- R4: A write to offset 0x8 clears each identity bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If an event sets an identity bit in the same cycle that a write to offset 0x8 clears it, the bit ends up set.
- R6: A write to offset 0x4 (mask) or offset 0xC (enable) replaces the whole register, and a read returns the value written.
- R7: `pend_vec` equals identity AND enable, and `pend_any` is the OR of `pend_vec`. Both change at the same edge as the register they depend on, so clearing a bit or the enable drops `pend_any`.
- R8: A read of offset 0x0 returns the event input levels at the read edge, and writes to offset 0x0 change no register.
- R9: `bus_rdata` is valid one cycle after `bus_rd_en`. Any offset other than 0x0, 0x4, 0x8 or 0xC, including unaligned ones, reads as zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W (4) | Byte offset |
| bus_wdata | input | NUM_EVT (32) | Write data |
| bus_rdata | output | NUM_EVT (32) | Read data, registered |
| evt_in | input | NUM_EVT (32) | Event lines, one per source |
| pend_vec | output | NUM_EVT (32) | Captured and enabled bits, toward the parent |
| pend_any | output | 1 | OR of `pend_vec` |

## Verification
The hardest case to reach is an event and an acknowledge of the same bit landing on the same edge. The bench drives the event line and the write to offset 0x8 from the same falling edge, so that both reach one rising edge. It then reads the register back to confirm the bit survived.

A second hard case is showing that a masked event stays lost. For this the bench pulses every line under a half mask, clears the mask, and reads the identity register again.

// File: rtl/irq_leaf_pkg.sv
package irq_leaf_pkg;
  localparam int OFF_LEVEL  = 'h0;
  localparam int OFF_MASK   = 'h4;
  localparam int OFF_IDENT  = 'h8;
  localparam int OFF_ENABLE = 'hC;

  typedef enum logic [1:0] {
    SEL_LEVEL  = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;
endpackage

// File: rtl/irq_leaf_decode.sv
module irq_leaf_decode
  import irq_leaf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_dec_t          dec
);
  always_comb begin
    dec.hit = 1'b1;
    dec.sel = SEL_LEVEL;
    if (addr == ADDR_W'(OFF_LEVEL))        dec.sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFF_MASK))    dec.sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_IDENT))   dec.sel = SEL_IDENT;
    else if (addr == ADDR_W'(OFF_ENABLE))  dec.sel = SEL_ENABLE;
    else                                   dec.hit = 1'b0;
  end
endmodule

// File: rtl/irq_leaf_ident.sv
module irq_leaf_ident #(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] ident_q,
  output logic [NUM_EVT-1:0] ident_d
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    // set has priority over clear in the same cycle
    assign ident_d[i] = set_vec[i] | (ident_q[i] & ~clr_vec[i]);
    always_ff @(posedge clk) begin
      if (rst) ident_q[i] <= 1'b0;
      else     ident_q[i] <= ident_d[i];
    end
  end

  // R3: a bit only rises when its set request was present
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ident_q & ~$past(ident_q) & ~$past(set_vec)) == '0));
  // R4: a cleared bit with no concurrent set is gone
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ident_q & $past(clr_vec & ~set_vec)) == '0));
  // R5: a set request always leaves the bit set
  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_vec) & ~ident_q) == '0));
endmodule

// File: rtl/irq_leaf_rdmux.sv
module irq_leaf_rdmux
  import irq_leaf_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  reg_dec_t           dec,
  input  logic [NUM_EVT-1:0] level,
  input  logic [NUM_EVT-1:0] mask,
  input  logic [NUM_EVT-1:0] ident,
  input  logic [NUM_EVT-1:0] enable,
  output logic [NUM_EVT-1:0] rdata_q
);
  logic [NUM_EVT-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_LEVEL:  sel_data = level;
        SEL_MASK:   sel_data = mask;
        SEL_IDENT:  sel_data = ident;
        SEL_ENABLE: sel_data = enable;
        default:    sel_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_data;
  end

  // R9: a read of an unused offset returns zero on the next cycle
  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !dec.hit) |=> (rdata_q == '0));
endmodule

// File: rtl/irq_leaf_unit.sv
module irq_leaf_unit
  import irq_leaf_pkg::*;
#(
  parameter int NUM_EVT = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_EVT-1:0] bus_wdata,
  output logic [NUM_EVT-1:0] bus_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [NUM_EVT-1:0] pend_vec,
  output logic               pend_any
);
  reg_dec_t           dec;
  logic               wr_mask, wr_ident, wr_enable;
  logic [NUM_EVT-1:0] mask_q, en_q, en_d;
  logic [NUM_EVT-1:0] ident_q, ident_d;
  logic [NUM_EVT-1:0] set_vec, clr_vec;
  logic [NUM_EVT-1:0] pend_q;
  logic               any_q;

  irq_leaf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_mask   = bus_wr_en && dec.hit && (dec.sel == SEL_MASK);
  assign wr_ident  = bus_wr_en && dec.hit && (dec.sel == SEL_IDENT);
  assign wr_enable = bus_wr_en && dec.hit && (dec.sel == SEL_ENABLE);

  assign set_vec = evt_in & ~mask_q;
  assign clr_vec = wr_ident ? bus_wdata : '0;
  assign en_d    = wr_enable ? bus_wdata : en_q;

  irq_leaf_ident #(.NUM_EVT(NUM_EVT)) u_ident (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .ident_q (ident_q),
    .ident_d (ident_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      en_q   <= '0;
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      en_q   <= en_d;
      pend_q <= ident_d & en_d;
      any_q  <= |(ident_d & en_d);
    end
  end

  irq_leaf_rdmux #(.NUM_EVT(NUM_EVT)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd_en),
    .dec     (dec),
    .level   (evt_in),
    .mask    (mask_q),
    .ident   (ident_q),
    .enable  (en_q),
    .rdata_q (bus_rdata)
  );

  assign pend_vec = pend_q;
  assign pend_any = any_q;

  // R7: the upstream vector tracks identity gated by enable
  p_pend_match_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_vec == (ident_q & en_q)));
  // R7: the summary flag follows the vector
  p_any_match_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_any == (pend_vec != '0)));
  // R6: the mask only changes on a write to its offset
  p_mask_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/tb_irq_leaf_unit.sv
module tb_irq_leaf_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr_en, bus_rd_en;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata, bus_rdata, evt_in, pend_vec;
  logic          pend_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] exp_mask, exp_ident, exp_en, rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_leaf_unit #(.NUM_EVT(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .pend_vec(pend_vec), .pend_any(pend_any)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [N-1:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic check_pend(input string tag);
    check({tag, " pend_vec"}, pend_vec, exp_ident & exp_en);
    check({tag, " pend_any"}, {{(N-1){1'b0}}, pend_any}, {{(N-1){1'b0}}, |(exp_ident & exp_en)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_mask = '1; exp_ident = '0; exp_en = '0;

    // R1 reset state
    rdreg(4'h4, rd); check("R1 mask", rd, '1);
    rdreg(4'h8, rd); check("R1 ident", rd, '0);
    rdreg(4'hC, rd); check("R1 enable", rd, '0);
    check_pend("R1");

    // R6 full replace of mask and enable
    wr(4'h4, '0); exp_mask = '0;
    rdreg(4'h4, rd); check("R6 mask", rd, exp_mask);
    wr(4'hC, '1); exp_en = '1;
    rdreg(4'hC, rd); check("R6 enable", rd, exp_en);

    // R2 R4 R7 single-bit sweep
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i); exp_ident = N'(1) << i;
      check_pend("R2/R7 sweep");
      rdreg(4'h8, rd); check("R2 sticky", rd, exp_ident);
      wr(4'h8, N'(1) << i); exp_ident = '0;
      check_pend("R7 drop after clear");
    end

    // R3 masked events lost
    wr(4'h4, 32'hFFFF0000); exp_mask = 32'hFFFF0000;
    pulse('1); exp_ident = 32'h0000FFFF;
    rdreg(4'h8, rd); check("R3 masked", rd, exp_ident);
    wr(4'h4, '0); exp_mask = '0;
    @(negedge clk);
    rdreg(4'h8, rd); check("R3 not revived", rd, exp_ident);

    // R4 partial clear
    wr(4'h8, 32'h00FF00FF); exp_ident = 32'h0000FF00;
    rdreg(4'h8, rd); check("R4 partial", rd, exp_ident);
    check_pend("R4");
    wr(4'h8, '1); exp_ident = '0;

    // R5 event wins over clear
    pulse(32'h18); exp_ident = 32'h18;
    evt_in = 32'h8;
    wr(4'h8, 32'h18);
    evt_in = '0; exp_ident = 32'h8;
    rdreg(4'h8, rd); check("R5 event wins", rd, exp_ident);
    wr(4'h8, '1); exp_ident = '0;

    // R6 R7 pattern masks and enables
    wr(4'h4, 32'hA5A5A5A5); exp_mask = 32'hA5A5A5A5;
    rdreg(4'h4, rd); check("R6 mask pattern", rd, exp_mask);
    pulse('1); exp_ident = ~exp_mask;
    rdreg(4'h8, rd); check("R2 pattern capture", rd, exp_ident);
    wr(4'hC, 32'h0F0F0F0F); exp_en = 32'h0F0F0F0F;
    check_pend("R7 enable pattern");
    wr(4'hC, 32'h00F00000); exp_en = 32'h00F00000;
    check_pend("R7 enable gated off");
    wr(4'hC, '1); exp_en = '1;
    check_pend("R7 enable all");

    // R8 live level view, writes ignored
    evt_in = 32'h12345678;
    rdreg(4'h0, rd); check("R8 level", rd, 32'h12345678);
    evt_in = 32'h0;
    wr(4'h0, '1);
    rdreg(4'h0, rd); check("R8 level after write", rd, 32'h0);
    rdreg(4'h4, rd); check("R8 mask untouched", rd, exp_mask);
    rdreg(4'h8, rd); check("R8 ident untouched", rd, exp_ident);

    // R9 unused offsets
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 0) begin
        wr(AW'(a), 32'h5A5A5A5A);
        rdreg(AW'(a), rd); check("R9 miss reads zero", rd, '0);
      end
    end
    rdreg(4'h4, rd); check("R9 mask untouched", rd, exp_mask);
    rdreg(4'h8, rd); check("R9 ident untouched", rd, exp_ident);
    rdreg(4'hC, rd); check("R9 enable untouched", rd, exp_en);
    check_pend("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule